// File: doc/BRIEF.md
# Clocked Separate-Port Static Memory

This block is a clock-cycle model of a 1024-word by 4-bit static memory with distinct data-in and data-out buses. Two active-low controls steer it: a select that enables the part and a write strobe. With select high the part is idle. With select low and the strobe high it reads. With both low it is inside a write pulse. The output is never released. When the part is idle or writing it drives zeros. While a read access is still settling it drives an all-ones invalid marker, and a separate valid flag rises once the word on the output is real.

A write is committed on the trailing edge of the write pulse. This is the first clock edge at which the strobe is seen high after one or more edges that saw select and strobe both low. The address and data sampled at that edge are the ones stored, so the data bus is free to settle late during the pulse. If select stays low, the committed word then appears on the output after a write-recovery delay. The access delay and the recovery delay are parameters counted in clock edges. The array has no reset value.

Top module: `sepio_sram`

## Requirements
- R1: The array holds 2^ADDR_W words (1024 by default) of DATA_W bits (4 by default). A read of an address returns the last word committed to that address.
- R2: At an edge where select (`cs_n`) is sampled high, `dout` becomes 0 and `dvalid` becomes 0, whatever the strobe is doing.
- R3: At an edge where `cs_n` and `we_n` are both sampled low, `dout` becomes 0 and `dvalid` becomes 0.
- R4: A write commits at the first edge where `we_n` is sampled high after at least one edge that saw `cs_n` and `we_n` both low. It stores the `din` and `addr` sampled at that commit edge. Values of `din` during the low edges have no effect.
- R5: An access starts at a read edge (`cs_n` low, `we_n` high) when the previous edge was not a read, or the address differs from the previous read's address. From that edge, `dout` shows all ones (4'hF by default) with `dvalid` low for ACC_LAT edges. After that it shows the stored word with `dvalid` high.
- R6: A commit edge that is also a read edge starts an access with WR_LAT edges in place of ACC_LAT. It then shows the newly written word.
- R7: While reads repeat at the same address with no commit, a valid output keeps the same word and keeps `dvalid` high.
- R8: While `rst_n` is low, `dout` is 0, `dvalid` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when idle or writing, all ones while invalid |
| dvalid | output | 1 | High when dout carries a settled word |

## Verification
The bench targets write pulses in which `din` changes while the strobe is low. A design that sampled data at the leading edge of the pulse would store the early value. It also targets a read that follows a commit at the same address. A design that skipped the recovery delay would raise `dvalid` too early, and one that failed to forward the new word would return stale data. Other cases are deselects and address changes in the middle of an access, where a wrong design keeps `dvalid` high or skips the all-ones window. Write pulses that start with select high are also covered, where a wrong design commits a word that was never strobed.

// File: rtl/sepio_sram.sv
module sepio_sram #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 4,
  parameter int ACC_LAT = 1,
  parameter int WR_LAT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXL  = (ACC_LAT > WR_LAT) ? ACC_LAT : WR_LAT;
  localparam int LW    = (MAXL < 1) ? 1 : $clog2(MAXL + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_pend, prev_rd;
  logic [ADDR_W-1:0] last_addr;
  logic [LW-1:0]     rem;

  logic          rd, commit, fresh;
  logic [LW-1:0] rem_eff;
  logic [DATA_W-1:0] rd_word;

  assign rd      = !cs_n && we_n;
  assign commit  = wr_pend && we_n;
  assign fresh   = !prev_rd || (addr != last_addr) || commit;
  assign rem_eff = fresh ? (commit ? LW'(WR_LAT) : LW'(ACC_LAT)) : rem;
  assign rd_word = commit ? din : mem[addr];

  always_ff @(posedge clk)
    if (commit) mem[addr] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend   <= 1'b0;
      prev_rd   <= 1'b0;
      last_addr <= '0;
      rem       <= '0;
      dout      <= '0;
      dvalid    <= 1'b0;
    end else begin
      wr_pend <= commit ? 1'b0 : (wr_pend || (!cs_n && !we_n));
      prev_rd <= rd;
      if (!rd) begin
        rem    <= '0;
        dout   <= '0;
        dvalid <= 1'b0;
      end else begin
        last_addr <= addr;
        rem       <= (rem_eff == '0) ? '0 : rem_eff - 1'b1;
        dout      <= (rem_eff == '0) ? rd_word : {DATA_W{1'b1}};
        dvalid    <= (rem_eff == '0);
      end
    end
  end

  // R2
  deselect_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (dout == '0 && !dvalid));

  // R3
  write_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> (dout == '0 && !dvalid));

  // R5
  invalid_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n) |=> (dvalid || dout == {DATA_W{1'b1}}));

  // R7
  steady_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !cs_n && we_n && !wr_pend && addr == last_addr)
      |=> (dvalid && $stable(dout)));

  // R5
  valid_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid) |-> $past(!cs_n && we_n));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (dout == '0 && !dvalid && !wr_pend));
endmodule

// File: tb/tb_sepio_sram.sv
module tb_sepio_sram;
  localparam int AW = 10, DW = 4, ACC = 2, WRL = 1;
  logic clk = 0, rst_n = 0, cs_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic dvalid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sepio_sram #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(ACC), .WR_LAT(WRL)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dvalid(dvalid));

  logic [DW-1:0] rm [1<<AW];
  bit known [1<<AW];
  bit m_pend = 0, m_prev = 0;
  logic [AW-1:0] m_last = '0;
  int m_rem = 0;
  logic [DW-1:0] e_dout = '0;
  bit e_v = 0, e_chk_data = 1;
  string e_req = "R8";

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(bit c, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    bit rd = !c && w;
    bit cm = m_pend && w;
    bit nw;
    int r;
    if (cm) begin rm[a] = d; known[a] = 1; end
    m_pend = cm ? 0 : (m_pend || (!c && !w));
    e_chk_data = 1;
    if (!rd) begin
      e_dout = '0; e_v = 0; m_prev = 0; m_rem = 0;
      e_req = c ? "R2" : "R3";
    end else begin
      nw = !m_prev || a != m_last || cm;
      r = nw ? (cm ? WRL : ACC) : m_rem;
      e_req = cm ? "R6" : (nw ? "R5" : "R7");
      if (r == 0) begin
        e_dout = rm[a]; e_v = 1; e_chk_data = known[a];
        if (!cm && known[a] && !nw) e_req = "R7";
        else if (!cm) e_req = "R1";
      end else begin
        e_dout = '1; e_v = 0;
      end
      m_rem = (r == 0) ? 0 : r - 1;
      m_prev = 1; m_last = a;
    end
  endfunction

  task automatic cyc(bit c, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; addr = a; din = d;
    model(c, w, a, d);
    @(posedge clk); #3;
    check(dvalid == e_v, e_req, dvalid, e_v);
    if (e_chk_data) check(dout == e_dout, e_req, dout, e_dout);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) known[i] = 0;
    repeat (3) @(posedge clk);
    #3;
    // R8
    check(dout == 0 && !dvalid, "R8", dout, 0);
    @(negedge clk); rst_n = 1;
    // R4: din changes inside the pulse, trailing-edge value stored
    cyc(0, 0, 10'd5, 4'h3);
    cyc(0, 0, 10'd5, 4'h7);
    cyc(0, 1, 10'd5, 4'hA);
    // R6: recovery then forwarded word
    cyc(0, 1, 10'd5, 4'h0);
    cyc(0, 1, 10'd5, 4'h0);
    // R1 / R5: other address, write then read from idle
    cyc(0, 0, 10'd1023, 4'h6);
    cyc(1, 1, 10'd1023, 4'h9);
    cyc(1, 1, 10'd1023, 4'h0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 10'd1023, 4'h0);
    // R5: address change mid access, then deselect mid access
    cyc(0, 1, 10'd5, 4'h0);
    cyc(0, 1, 10'd1023, 4'h0);
    cyc(1, 1, 10'd1023, 4'h0);
    cyc(0, 1, 10'd5, 4'h0);
    cyc(0, 1, 10'd5, 4'h0);
    cyc(0, 1, 10'd5, 4'h0);
    // R2: strobe low with select high
    cyc(1, 0, 10'd5, 4'h1);
    cyc(1, 1, 10'd5, 4'h1);
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int p = $urandom_range(0, 9);
      cyc(p < 2, p >= 2 && p < 5 ? 1'b0 : 1'b1,
          AW'($urandom_range(0, 7) * 73), DW'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule